// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

This block keeps count of the flow-control credits that the link partner has granted for two traffic classes: posted and non-posted. Each class has a header pool and a data pool. One data credit covers 16 bytes of payload. When the transmit path acknowledges a packet, the block takes one header credit and ceil(bytes/16) data credits from the pools of that packet's class. When the receive side reports released credits, the block adds them back.

The application reads a compact 11-bit status word, `credit_vec`, to decide what it may send next. The word holds a one-bit "a packet fits" header flag for each class and a saturating 9-bit count of posted data credits. A class that was granted unlimited credit at load time reports its fields at their maximum and never loses credits. If an acknowledge arrives for a finite class that lacks the header or data credit it needs, the block raises an error pulse and leaves that class's credits as they were.

Top module: `txfc_credit_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `credit_vec` and `ack_err` read all zeros. Every class reads "no credits" until a load strobe arrives.
- R2: The load strobe `ld_en` sets the limits of both classes and clears their consumed counts. The cycle after the load, bit 0 (posted header) reads 1 exactly when the posted header limit is non-zero, bits [9:1] show the posted data limit, and bit 10 (non-posted header) reads 1 exactly when the non-posted header limit is non-zero.
- R3: Bits [9:1] never exceed 256. When more than 256 posted data credits are held, they read 256.
- R4: An accepted posted acknowledge removes one posted header credit and ceil(`ack_bytes`/16) posted data credits. `credit_vec` shows the deduction in the cycle after the acknowledge.
- R5: An accepted non-posted acknowledge (`ack_np`=1) removes one non-posted header credit and its data credits, and updates bit 10. The posted fields do not change.
- R6: When a class was loaded with its infinite flag set, its header flag reads 1, its data field (bits [9:1] for posted) reads 256, and acknowledges never reduce it or raise `ack_err`.
- R7: An acknowledge for a finite class with no header credit, or with fewer data credits than it needs, raises `ack_err` for one cycle in the cycle after it. The class's credit counts stay unchanged.
- R8: A return (`rtn_en`, class chosen by `rtn_np`) adds `rtn_hdr` header credits and `rtn_data` data credits to that class. The result is visible the cycle after.
- R9: A return and an acknowledge in the same cycle are both applied. Whether the acknowledge is accepted is judged on the credits held before that cycle's return.
- R10: Limit and consumed counts wrap modulo their widths, so availability stays correct after more than 4096 data credits or 256 header credits have passed through a class.
- R11: A load in the same cycle as an acknowledge or a return takes precedence. The acknowledge and the return are dropped and `ack_err` stays 0.
- R12: An acknowledge with zero payload bytes consumes one header credit and no data credit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe for initial limits |
| ld_p_hdr | input | 8 | Posted header credit limit |
| ld_p_data | input | 12 | Posted data credit limit |
| ld_p_inf | input | 1 | Posted class has infinite credit |
| ld_np_hdr | input | 8 | Non-posted header credit limit |
| ld_np_data | input | 12 | Non-posted data credit limit |
| ld_np_inf | input | 1 | Non-posted class has infinite credit |
| rtn_en | input | 1 | Credit return valid |
| rtn_np | input | 1 | Return class: 0 posted, 1 non-posted |
| rtn_hdr | input | 8 | Header credits returned |
| rtn_data | input | 12 | Data credits returned |
| ack_en | input | 1 | Packet acknowledge strobe |
| ack_np | input | 1 | Acknowledged class: 0 posted, 1 non-posted |
| ack_bytes | input | 13 | Payload length of the acknowledged packet in bytes (0 to 4096) |
| credit_vec | output | 11 | Status: [0] posted header flag, [9:1] posted data count, [10] non-posted header flag |
| ack_err | output | 1 | Acknowledge rejected for lack of credit |

## Verification
The bench builds the block with its default widths: 8-bit header counters, 12-bit data counters and a 13-bit byte length. With these sizes a few hundred paired acknowledge-and-return cycles drive both the data and the header consumed counts past their wrap points, and a single 4096-byte packet exactly matches the 256-credit saturation point of the status field. The directed scenarios cover the cases where cycle timing matters: same-cycle return plus acknowledge, load overriding traffic, rejection with unchanged counts, and infinite classes under heavy acknowledge traffic.

// File: rtl/txfc_pkg.sv
package txfc_pkg;
  localparam int NUM_CLASSES = 2;
  localparam int CLS_POSTED  = 0;
  localparam int CLS_NONPOST = 1;
  localparam int BYTES_PER_CREDIT_LOG2 = 4;
  localparam int DATA_REPORT_MAX = 256;
  localparam int DATA_REPORT_W   = 9;
endpackage

// File: rtl/txfc_credit_pool.sv
module txfc_credit_pool #(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [HDR_W-1:0]  load_hdr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_inf,
  input  logic              ret_vld,
  input  logic [HDR_W-1:0]  ret_hdr,
  input  logic [DATA_W-1:0] ret_data,
  input  logic              ack_vld,
  input  logic [DATA_W-1:0] need_data,
  output logic [HDR_W-1:0]  hdr_avail_nxt,
  output logic [DATA_W-1:0] data_avail_nxt,
  output logic              inf_nxt,
  output logic              reject
);
  logic [HDR_W-1:0]  hdr_lim_q,  hdr_lim_d,  hdr_used_q,  hdr_used_d;
  logic [DATA_W-1:0] data_lim_q, data_lim_d, data_used_q, data_used_d;
  logic              inf_q, inf_d;
  logic [HDR_W-1:0]  hdr_avail;
  logic [DATA_W-1:0] data_avail;
  logic              fits;

  assign hdr_avail  = hdr_lim_q - hdr_used_q;
  assign data_avail = data_lim_q - data_used_q;
  assign fits       = inf_q || ((hdr_avail != '0) && (data_avail >= need_data));
  assign reject     = ack_vld && !load && !fits;

  always_comb begin
    hdr_lim_d   = hdr_lim_q;
    data_lim_d  = data_lim_q;
    hdr_used_d  = hdr_used_q;
    data_used_d = data_used_q;
    inf_d       = inf_q;
    if (load) begin
      hdr_lim_d   = load_hdr;
      data_lim_d  = load_data;
      hdr_used_d  = '0;
      data_used_d = '0;
      inf_d       = load_inf;
    end else begin
      if (ret_vld) begin
        hdr_lim_d  = hdr_lim_q + ret_hdr;
        data_lim_d = data_lim_q + ret_data;
      end
      if (ack_vld && fits && !inf_q) begin
        hdr_used_d  = hdr_used_q + HDR_W'(1);
        data_used_d = data_used_q + need_data;
      end
    end
  end

  assign hdr_avail_nxt  = hdr_lim_d - hdr_used_d;
  assign data_avail_nxt = data_lim_d - data_used_d;
  assign inf_nxt        = inf_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_lim_q   <= '0;
      data_lim_q  <= '0;
      hdr_used_q  <= '0;
      data_used_q <= '0;
      inf_q       <= 1'b0;
    end else begin
      hdr_lim_q   <= hdr_lim_d;
      data_lim_q  <= data_lim_d;
      hdr_used_q  <= hdr_used_d;
      data_used_q <= data_used_d;
      inf_q       <= inf_d;
    end
  end

  // R4
  deduct_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && !load && !ret_vld && fits && !inf_q)
      |=> ((data_lim_q - data_used_q) == $past(data_avail) - $past(need_data))
          && ((hdr_lim_q - hdr_used_q) == $past(hdr_avail) - HDR_W'(1)));

  // R7
  reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
    reject |=> ($stable(data_used_q) && $stable(hdr_used_q)));

  // R6
  inf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (inf_q && !load) |=> ($stable(data_used_q) && $stable(hdr_used_q)));
endmodule

// File: rtl/txfc_status_enc.sv
module txfc_status_enc
  import txfc_pkg::*;
#(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12
) (
  input  logic [HDR_W-1:0]  p_hdr_avail,
  input  logic [DATA_W-1:0] p_data_avail,
  input  logic              p_inf,
  input  logic [HDR_W-1:0]  np_hdr_avail,
  input  logic              np_inf,
  output logic [DATA_REPORT_W+1:0] status
);
  localparam logic [DATA_W-1:0] SAT_D = DATA_W'(DATA_REPORT_MAX);
  localparam logic [DATA_REPORT_W-1:0] SAT_R = DATA_REPORT_W'(DATA_REPORT_MAX);

  logic                     p_flag, np_flag;
  logic [DATA_REPORT_W-1:0] p_cnt;

  always_comb begin
    p_flag  = p_inf  || (p_hdr_avail  != '0);
    np_flag = np_inf || (np_hdr_avail != '0);
    if (p_inf || (p_data_avail > SAT_D)) p_cnt = SAT_R;
    else                                 p_cnt = p_data_avail[DATA_REPORT_W-1:0];
    status = {np_flag, p_cnt, p_flag};
  end
endmodule

// File: rtl/txfc_credit_tracker.sv
module txfc_credit_tracker
  import txfc_pkg::*;
#(
  parameter int HDR_W  = 8,
  parameter int DATA_W = 12,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [HDR_W-1:0]  ld_p_hdr,
  input  logic [DATA_W-1:0] ld_p_data,
  input  logic              ld_p_inf,
  input  logic [HDR_W-1:0]  ld_np_hdr,
  input  logic [DATA_W-1:0] ld_np_data,
  input  logic              ld_np_inf,
  input  logic              rtn_en,
  input  logic              rtn_np,
  input  logic [HDR_W-1:0]  rtn_hdr,
  input  logic [DATA_W-1:0] rtn_data,
  input  logic              ack_en,
  input  logic              ack_np,
  input  logic [LEN_W-1:0]  ack_bytes,
  output logic [DATA_REPORT_W+1:0] credit_vec,
  output logic              ack_err
);
  localparam int RND_W  = LEN_W + 1;
  localparam int NEED_W = RND_W - BYTES_PER_CREDIT_LOG2;
  localparam logic [RND_W-1:0] RND_ADD = RND_W'((1 << BYTES_PER_CREDIT_LOG2) - 1);

  logic [RND_W-1:0]  bytes_rnd;
  logic [NEED_W-1:0] need_raw;
  logic [DATA_W-1:0] need_data;

  assign bytes_rnd = {1'b0, ack_bytes} + RND_ADD;
  assign need_raw  = bytes_rnd[RND_W-1:BYTES_PER_CREDIT_LOG2];
  assign need_data = DATA_W'(need_raw);

  logic [HDR_W-1:0]  lim_hdr_a   [NUM_CLASSES];
  logic [DATA_W-1:0] lim_data_a  [NUM_CLASSES];
  logic              lim_inf_a   [NUM_CLASSES];
  logic [HDR_W-1:0]  hdr_nxt_a   [NUM_CLASSES];
  logic [DATA_W-1:0] data_nxt_a  [NUM_CLASSES];
  logic              inf_nxt_a   [NUM_CLASSES];
  logic [NUM_CLASSES-1:0] rej_a;

  assign lim_hdr_a[CLS_POSTED]   = ld_p_hdr;
  assign lim_hdr_a[CLS_NONPOST]  = ld_np_hdr;
  assign lim_data_a[CLS_POSTED]  = ld_p_data;
  assign lim_data_a[CLS_NONPOST] = ld_np_data;
  assign lim_inf_a[CLS_POSTED]   = ld_p_inf;
  assign lim_inf_a[CLS_NONPOST]  = ld_np_inf;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_pool
    logic sel_ack, sel_ret;
    assign sel_ack = ack_en && (int'(ack_np) == c);
    assign sel_ret = rtn_en && (int'(rtn_np) == c);
    txfc_credit_pool #(.HDR_W(HDR_W), .DATA_W(DATA_W)) pool_i (
      .clk            (clk),
      .rst            (rst),
      .load           (ld_en),
      .load_hdr       (lim_hdr_a[c]),
      .load_data      (lim_data_a[c]),
      .load_inf       (lim_inf_a[c]),
      .ret_vld        (sel_ret),
      .ret_hdr        (rtn_hdr),
      .ret_data       (rtn_data),
      .ack_vld        (sel_ack),
      .need_data      (need_data),
      .hdr_avail_nxt  (hdr_nxt_a[c]),
      .data_avail_nxt (data_nxt_a[c]),
      .inf_nxt        (inf_nxt_a[c]),
      .reject         (rej_a[c])
    );
  end

  logic [DATA_REPORT_W+1:0] status_d;

  txfc_status_enc #(.HDR_W(HDR_W), .DATA_W(DATA_W)) enc_i (
    .p_hdr_avail  (hdr_nxt_a[CLS_POSTED]),
    .p_data_avail (data_nxt_a[CLS_POSTED]),
    .p_inf        (inf_nxt_a[CLS_POSTED]),
    .np_hdr_avail (hdr_nxt_a[CLS_NONPOST]),
    .np_inf       (inf_nxt_a[CLS_NONPOST]),
    .status       (status_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_vec <= '0;
      ack_err    <= 1'b0;
    end else begin
      credit_vec <= status_d;
      ack_err    <= |rej_a;
    end
  end

  // R3
  pd_range_chk: assert property (@(posedge clk) disable iff (rst)
    credit_vec[DATA_REPORT_W:1] <= DATA_REPORT_W'(DATA_REPORT_MAX));

  // R7
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    ack_err |-> ($past(ack_en) && !$past(ld_en)));

  // R11
  load_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> !ack_err);
endmodule

// File: tb/txfc_credit_tracker_tb.sv
module txfc_credit_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 0, ld_p_inf = 0, ld_np_inf = 0;
  logic [7:0]  ld_p_hdr = 0, ld_np_hdr = 0, rtn_hdr = 0;
  logic [11:0] ld_p_data = 0, ld_np_data = 0, rtn_data = 0;
  logic        rtn_en = 0, rtn_np = 0, ack_en = 0, ack_np = 0;
  logic [12:0] ack_bytes = 0;
  logic [10:0] credit_vec;
  logic        ack_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  txfc_credit_tracker dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en),
    .ld_p_hdr(ld_p_hdr), .ld_p_data(ld_p_data), .ld_p_inf(ld_p_inf),
    .ld_np_hdr(ld_np_hdr), .ld_np_data(ld_np_data), .ld_np_inf(ld_np_inf),
    .rtn_en(rtn_en), .rtn_np(rtn_np), .rtn_hdr(rtn_hdr), .rtn_data(rtn_data),
    .ack_en(ack_en), .ack_np(ack_np), .ack_bytes(ack_bytes),
    .credit_vec(credit_vec), .ack_err(ack_err)
  );

  task automatic step();
    @(posedge clk); #1;
    ld_en = 0; rtn_en = 0; ack_en = 0;
  endtask

  task automatic chk_vec(input bit ph, input int pd, input bit nph, input bit err, input string req);
    logic [10:0] exp;
    exp = {nph, 9'(pd), ph};
    n_chk++;
    if (credit_vec !== exp || ack_err !== err) begin
      n_bad++;
      $display("FAIL %s: vec=%h err=%b expected vec=%h err=%b", req, credit_vec, ack_err, exp, err);
    end
  endtask

  task automatic load(input int ph, input int pd, input bit pinf, input int nph, input int npd, input bit npinf);
    ld_en = 1; ld_p_hdr = 8'(ph); ld_p_data = 12'(pd); ld_p_inf = pinf;
    ld_np_hdr = 8'(nph); ld_np_data = 12'(npd); ld_np_inf = npinf;
  endtask

  task automatic ack(input bit np, input int bytes);
    ack_en = 1; ack_np = np; ack_bytes = 13'(bytes);
  endtask

  task automatic ret(input bit np, input int h, input int d);
    rtn_en = 1; rtn_np = np; rtn_hdr = 8'(h); rtn_data = 12'(d);
  endtask

  task automatic t_reset();
    chk_vec(0, 0, 0, 0, "R1 reset");
  endtask

  task automatic t_load();
    load(4, 100, 0, 2, 50, 0); step();
    chk_vec(1, 100, 1, 0, "R2 load");
    load(0, 7, 0, 0, 9, 0); step();
    chk_vec(0, 7, 0, 0, "R2 zero header limit");
  endtask

  task automatic t_sat();
    load(8, 1000, 0, 1, 1, 0); step();
    chk_vec(1, 256, 1, 0, "R3 saturate on load");
    ack(0, 4096); step();
    chk_vec(1, 256, 1, 0, "R3 744 left");
    ack(0, 4096); step();
    chk_vec(1, 256, 1, 0, "R3 488 left");
    ack(0, 4096); step();
    chk_vec(1, 232, 1, 0, "R3 232 below cap");
  endtask

  task automatic t_ack_posted();
    load(2, 10, 0, 1, 4, 0); step();
    ack(0, 33); step();
    chk_vec(1, 7, 1, 0, "R4 ceil(33/16)=3");
    ack(0, 16); step();
    chk_vec(0, 6, 1, 0, "R4 last header");
  endtask

  task automatic t_np();
    load(2, 10, 0, 1, 4, 0); step();
    ack(1, 4); step();
    chk_vec(1, 10, 0, 0, "R5 np ack");
    ack(1, 0); step();
    chk_vec(1, 10, 0, 1, "R7 np no header");
  endtask

  task automatic t_inf();
    load(1, 3, 1, 0, 0, 1); step();
    chk_vec(1, 256, 1, 0, "R6 infinite load");
    for (int i = 0; i < 4; i++) begin
      ack(i[0], 4096); step();
      chk_vec(1, 256, 1, 0, "R6 infinite ack");
    end
  endtask

  task automatic t_reject();
    load(1, 2, 0, 1, 1, 0); step();
    ack(0, 48); step();
    chk_vec(1, 2, 1, 1, "R7 short data");
    step();
    chk_vec(1, 2, 1, 0, "R7 err one cycle");
    ack(0, 32); step();
    chk_vec(0, 0, 1, 0, "R7 fitting ack after reject");
    ack(0, 0); step();
    chk_vec(0, 0, 1, 1, "R7 no header");
  endtask

  task automatic t_return();
    load(0, 0, 0, 0, 0, 0); step();
    ret(0, 3, 20); step();
    chk_vec(1, 20, 0, 0, "R8 posted return");
    ret(1, 1, 5); step();
    chk_vec(1, 20, 1, 0, "R8 np return");
  endtask

  task automatic t_ret_ack();
    load(1, 5, 0, 0, 0, 0); step();
    ret(0, 1, 10); ack(0, 80); step();
    chk_vec(1, 10, 0, 0, "R9 same cycle return and ack");
    load(0, 0, 0, 0, 0, 0); step();
    ret(0, 1, 4); ack(0, 16); step();
    chk_vec(1, 4, 0, 1, "R9 judged before return");
  endtask

  task automatic t_wrap();
    load(1, 256, 0, 0, 0, 0); step();
    for (int i = 0; i < 300; i++) begin
      ret(0, 1, 256); ack(0, 4096); step();
      if (i == 20 || i == 299) chk_vec(1, 256, 0, 0, "R10 wrap steady");
    end
    ack(0, 4096); step();
    chk_vec(0, 0, 0, 0, "R10 final drain");
  endtask

  task automatic t_load_ovr();
    load(3, 30, 0, 2, 2, 0); step();
    load(2, 20, 0, 1, 1, 0); ack(0, 64); ret(0, 5, 5); step();
    chk_vec(1, 20, 1, 0, "R11 load overrides");
  endtask

  task automatic t_zero();
    load(1, 3, 0, 0, 0, 0); step();
    ack(0, 0); step();
    chk_vec(0, 3, 0, 0, "R12 zero length");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst = 0;
    step();
    t_reset();
    t_load();
    t_sat();
    t_ack_posted();
    t_np();
    t_inf();
    t_reject();
    t_return();
    t_ret_ack();
    t_wrap();
    t_load_ovr();
    t_zero();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule